// File: doc/BRIEF.md
# Offset-Binary Distributed-Arithmetic Row Generator

This combinational block builds every operand row that an adder tree needs to form one part of a complex product. Only two precombined coefficients reach it: S = −(CR − CI) and T = −(CR + CI). It does not take the raw real and imaginary coefficients. For each bit position of the data words it looks at the real and imaginary data bits together. It uses their agreement to choose S or T, and it uses one of the two bits to decide whether to take the one's complement. A single select line chooses the real-part formulas or the imaginary-part formulas, so one downstream adder tree can be shared by the two halves of the product in alternate cycles.

The rows are already shifted into position in a common sum width. Sign extension is replaced by inverting the top bit of each row. The block also produces one correction word. It folds together four terms: the +1 still owed by every complemented row, the negative weight of the sign row, the offset term of the coding, and the constant that the sign-bit inversion requires. The sum of all rows plus the correction word, taken modulo 2^SUM_W and read as signed, equals twice the selected part of the product. The block does not precompute coefficients and does not add the rows.

Top module: `obpp_generator`

## Requirements
- R1: With sel_real=1, for bit k below DATA_W−1, the row pattern before sign inversion is coef_s when data_re[k]==data_im[k] and coef_t otherwise. The pattern is bitwise complemented when data_re[k]=1.
- R2: With sel_real=0, for bit k below DATA_W−1, the pattern is coef_t when the two data bits agree and coef_s otherwise. It is bitwise complemented when data_im[k]=1.
- R3: The row for bit DATA_W−1 (the data sign bit) carries the bitwise complement of the pattern that R1 or R2 would give for that position.
- R4: Row k of pp_rows is SUM_W bits wide. It holds its COEF_W-bit pattern at bits [k+COEF_W−1:k] with the pattern's top bit inverted. All other bits are zero.
- R5: pp_offset = sign-extended (coef_s if sel_real else coef_t) + (selected data word + 2^(DATA_W−1)) + 2^(COEF_W−1) − 2^(COEF_W+DATA_W−1), modulo 2^SUM_W. The selected data word is data_re when sel_real=1 and data_im otherwise, read as signed.
- R6: With sel_real=1, the sum of all rows and pp_offset, modulo 2^SUM_W, equals −(S+T)·XR + (T−S)·XI, which is 2·(CR·XR − CI·XI).
- R7: With sel_real=0, that sum equals −(S+T)·XI + (S−T)·XR, which is 2·(CR·XI + CI·XR).
- R8: R6 and R7 hold at the extremes, including the most negative and most positive values of S, T, XR and XI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_real | input | 1 | 1 selects the real-part rows, 0 selects the imaginary-part rows |
| coef_s | input | COEF_W | Precombined coefficient S = −(CR−CI), two's complement |
| coef_t | input | COEF_W | Precombined coefficient T = −(CR+CI), two's complement |
| data_re | input | DATA_W | Real data word XR, two's complement |
| data_im | input | DATA_W | Imaginary data word XI, two's complement |
| pp_rows | output | DATA_W × SUM_W | Shifted, sign-handled operand rows, row k at index k |
| pp_offset | output | SUM_W | Correction word that completes the sum |

## Verification
The assertions are evaluated on every input change. They cover the coefficient choice and the complementing of each row, the zero bits around each placed row, and the full modular identity between the rows plus the correction word and the multiplied-out product. The correction word is checked against its own closed form only in the bench. The bench's sweep of extreme coefficient and data combinations in both modes is the only place where the most negative corners are certain to be reached.

// File: rtl/obpp_pkg.sv
package obpp_pkg;

    parameter int unsigned COEF_W_DEF = 17;
    parameter int unsigned DATA_W_DEF = 13;

    typedef enum logic {
        PART_IMAG = 1'b0,
        PART_REAL = 1'b1
    } part_e;

    // Per-bit steering produced by the operand mux and consumed by a row slice.
    typedef struct packed {
        logic eq;    // real and imaginary data bits agree
        logic flag;  // data bit that controls complementing
        logic msb;   // this slice handles the data sign bit
    } bit_ctl_t;

    function automatic int unsigned sum_width(input int unsigned cw, input int unsigned dw);
        return cw + dw + 1;
    endfunction

endpackage

// File: rtl/obpp_operand_mux.sv
module obpp_operand_mux
    import obpp_pkg::*;
#(
    parameter int unsigned COEF_W = COEF_W_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF
) (
    input  part_e                    part,
    input  logic [COEF_W-1:0]        coef_s,
    input  logic [COEF_W-1:0]        coef_t,
    input  logic [DATA_W-1:0]        data_re,
    input  logic [DATA_W-1:0]        data_im,
    output logic [COEF_W-1:0]        coef_eq,
    output logic [COEF_W-1:0]        coef_ne,
    output logic [DATA_W-1:0]        flag_word,
    output bit_ctl_t [DATA_W-1:0]    ctl
);

    // The select swaps the two coefficients once and picks the controlling data word.
    assign coef_eq   = (part == PART_REAL) ? coef_s  : coef_t;
    assign coef_ne   = (part == PART_REAL) ? coef_t  : coef_s;
    assign flag_word = (part == PART_REAL) ? data_re : data_im;

    for (genvar k = 0; k < DATA_W; k++) begin : g_ctl
        assign ctl[k] = {~(data_re[k] ^ data_im[k]), flag_word[k], 1'(k == DATA_W - 1)};
    end

endmodule

// File: rtl/obpp_row_slice.sv
module obpp_row_slice
    import obpp_pkg::*;
#(
    parameter int unsigned COEF_W = COEF_W_DEF,
    parameter int unsigned SUM_W  = sum_width(COEF_W_DEF, DATA_W_DEF),
    parameter int unsigned SHIFT  = 0
) (
    input  bit_ctl_t             ctl,
    input  logic [COEF_W-1:0]    coef_eq,
    input  logic [COEF_W-1:0]    coef_ne,
    output logic [SUM_W-1:0]     row
);

    logic [COEF_W-1:0] picked;
    logic [COEF_W-1:0] pattern;
    logic [COEF_W-1:0] body;

    assign picked  = ctl.eq ? coef_eq : coef_ne;
    // Sign row is subtracted: one extra inversion folds the negation in.
    assign pattern = picked ^ {COEF_W{ctl.flag ^ ctl.msb}};
    // Inverted top bit stands in for sign extension.
    assign body    = {~pattern[COEF_W-1], pattern[COEF_W-2:0]};

    always_comb begin
        row = '0;
        row[SHIFT +: COEF_W] = body;
    end

endmodule

// File: rtl/obpp_offset_word.sv
module obpp_offset_word
    import obpp_pkg::*;
#(
    parameter int unsigned COEF_W = COEF_W_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned SUM_W  = sum_width(COEF_W_DEF, DATA_W_DEF)
) (
    input  logic [COEF_W-1:0]    coef_eq,
    input  logic [DATA_W-1:0]    flag_word,
    output logic [SUM_W-1:0]     offset
);

    localparam logic [SUM_W-1:0] ONE      = SUM_W'(1);
    // Sum over all rows of -2^(COEF_W-1) * 2^k, i.e. the sign-inversion fix.
    localparam logic [SUM_W-1:0] SIGN_FIX = (ONE << (COEF_W - 1)) - (ONE << (COEF_W + DATA_W - 1));

    logic [SUM_W-1:0] coef_ext;
    logic [SUM_W-1:0] lsb_terms;

    assign coef_ext  = {{(SUM_W - COEF_W){coef_eq[COEF_W-1]}}, coef_eq};
    // Pending +1 of each complemented row, plus the sign row's 2^(DATA_W-1) when not complemented:
    // this is the controlling data word in offset binary.
    assign lsb_terms = {{(SUM_W - DATA_W){1'b0}}, ~flag_word[DATA_W-1], flag_word[DATA_W-2:0]};
    assign offset    = coef_ext + lsb_terms + SIGN_FIX;

endmodule

// File: rtl/obpp_generator.sv
module obpp_generator
    import obpp_pkg::*;
#(
    parameter int unsigned COEF_W = COEF_W_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned SUM_W  = sum_width(COEF_W, DATA_W)
) (
    input  logic                               sel_real,
    input  logic [COEF_W-1:0]                  coef_s,
    input  logic [COEF_W-1:0]                  coef_t,
    input  logic [DATA_W-1:0]                  data_re,
    input  logic [DATA_W-1:0]                  data_im,
    output logic [DATA_W-1:0][SUM_W-1:0]       pp_rows,
    output logic [SUM_W-1:0]                   pp_offset
);

    part_e                  part;
    logic [COEF_W-1:0]      coef_eq;
    logic [COEF_W-1:0]      coef_ne;
    logic [DATA_W-1:0]      flag_word;
    bit_ctl_t [DATA_W-1:0]  ctl;

    assign part = part_e'(sel_real);

    obpp_operand_mux #(
        .COEF_W (COEF_W),
        .DATA_W (DATA_W)
    ) u_mux (
        .part      (part),
        .coef_s    (coef_s),
        .coef_t    (coef_t),
        .data_re   (data_re),
        .data_im   (data_im),
        .coef_eq   (coef_eq),
        .coef_ne   (coef_ne),
        .flag_word (flag_word),
        .ctl       (ctl)
    );

    for (genvar k = 0; k < DATA_W; k++) begin : g_row
        obpp_row_slice #(
            .COEF_W (COEF_W),
            .SUM_W  (SUM_W),
            .SHIFT  (k)
        ) u_slice (
            .ctl     (ctl[k]),
            .coef_eq (coef_eq),
            .coef_ne (coef_ne),
            .row     (pp_rows[k])
        );
    end

    obpp_offset_word #(
        .COEF_W (COEF_W),
        .DATA_W (DATA_W),
        .SUM_W  (SUM_W)
    ) u_offset (
        .coef_eq   (coef_eq),
        .flag_word (flag_word),
        .offset    (pp_offset)
    );

    // ------------------------------------------------------------------
    // Assertions
    // ------------------------------------------------------------------
    localparam logic [SUM_W-1:0]  ONE_S = SUM_W'(1);
    localparam logic [COEF_W-1:0] TOP_C = COEF_W'(1) << (COEF_W - 1);

    logic signed [SUM_W-1:0] s_x, t_x, re_x, im_x, ref_re, ref_im;
    logic        [SUM_W-1:0] total;
    logic        [SUM_W-1:0] keep_mask;
    logic        [COEF_W-1:0] restored;
    logic        [COEF_W-1:0] expect_pat;
    logic                     flip;

    always_comb begin
        s_x    = {{(SUM_W - COEF_W){coef_s[COEF_W-1]}}, coef_s};
        t_x    = {{(SUM_W - COEF_W){coef_t[COEF_W-1]}}, coef_t};
        re_x   = {{(SUM_W - DATA_W){data_re[DATA_W-1]}}, data_re};
        im_x   = {{(SUM_W - DATA_W){data_im[DATA_W-1]}}, data_im};
        ref_re = -(s_x + t_x) * re_x + (t_x - s_x) * im_x;
        ref_im = -(s_x + t_x) * im_x + (s_x - t_x) * re_x;
        total  = pp_offset;
        for (int k = 0; k < DATA_W; k++) begin
            total = total + pp_rows[k];
        end
        if (sel_real) begin
            AST_REAL_SUM: assert (total == ref_re)   // R6
                else $error("real-part rows do not sum to the product");
        end else begin
            AST_IMAG_SUM: assert (total == ref_im)   // R7
                else $error("imaginary-part rows do not sum to the product");
        end
    end

    always_comb begin
        keep_mask  = '0;
        restored   = '0;
        expect_pat = '0;
        flip       = 1'b0;
        for (int k = 0; k < DATA_W; k++) begin
            keep_mask = ((ONE_S << (k + COEF_W)) - 1) & ~((ONE_S << k) - 1);
            AST_ROW_OUTSIDE_CLEAR: assert ((pp_rows[k] & ~keep_mask) == '0)   // R4
                else $error("row %0d has bits outside its window", k);
            restored = pp_rows[k][k +: COEF_W] ^ TOP_C;
            flip     = (sel_real ? data_re[k] : data_im[k]) ^ (k == DATA_W - 1);
            if (data_re[k] == data_im[k]) begin
                expect_pat = sel_real ? coef_s : coef_t;
                AST_MATCHED_BITS_PICK: assert (restored == (expect_pat ^ {COEF_W{flip}}))   // R1 R2 R3
                    else $error("row %0d wrong for agreeing data bits", k);
            end else begin
                expect_pat = sel_real ? coef_t : coef_s;
                AST_SPLIT_BITS_PICK: assert (restored == (expect_pat ^ {COEF_W{flip}}))   // R1 R2 R3
                    else $error("row %0d wrong for differing data bits", k);
            end
        end
    end

endmodule

// File: tb/obpp_generator_test.sv
module obpp_generator_test;

    localparam int CW = 17;
    localparam int DW = 13;
    localparam int SW = CW + DW + 1;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    sel_real;
    logic [CW-1:0]           coef_s;
    logic [CW-1:0]           coef_t;
    logic [DW-1:0]           data_re;
    logic [DW-1:0]           data_im;
    logic [DW-1:0][SW-1:0]   pp_rows;
    logic [SW-1:0]           pp_offset;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    obpp_generator #(.COEF_W(CW), .DATA_W(DW)) uut (
        .sel_real  (sel_real),
        .coef_s    (coef_s),
        .coef_t    (coef_t),
        .data_re   (data_re),
        .data_im   (data_im),
        .pp_rows   (pp_rows),
        .pp_offset (pp_offset)
    );

    task automatic chk(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Row k from the selection table of R1/R2, complemented for the sign row (R3), placed per R4.
    function automatic logic [SW-1:0] exp_row(input int k, input logic m, input logic rb, input logic ib,
                                              input logic [CW-1:0] s, input logic [CW-1:0] t);
        logic [CW-1:0] pat;
        if (m) begin
            case ({rb, ib})
                2'b00:   pat = s;
                2'b01:   pat = t;
                2'b10:   pat = ~t;
                default: pat = ~s;
            endcase
        end else begin
            case ({rb, ib})
                2'b00:   pat = t;
                2'b01:   pat = ~s;
                2'b10:   pat = s;
                default: pat = ~t;
            endcase
        end
        if (k == DW - 1) pat = ~pat;
        pat[CW-1] = ~pat[CW-1];
        return SW'(pat) << k;
    endfunction

    task automatic check_now(input string note);
        longint s_i, t_i, re_i, im_i, prod, corr;
        logic [SW-1:0] acc;
        s_i  = longint'($signed(coef_s));
        t_i  = longint'($signed(coef_t));
        re_i = longint'($signed(data_re));
        im_i = longint'($signed(data_im));
        for (int k = 0; k < DW; k++) begin
            chk($sformatf("%s row %0d %s", (k == DW - 1) ? "R3 R4" : (sel_real ? "R1 R4" : "R2 R4"), k, note),
                pp_rows[k], exp_row(k, sel_real, data_re[k], data_im[k], coef_s, coef_t));
        end
        corr = (sel_real ? s_i : t_i) + (sel_real ? re_i : im_i) + (longint'(1) << (DW - 1))
             + (longint'(1) << (CW - 1)) - (longint'(1) << (CW + DW - 1));
        chk($sformatf("R5 offset %s", note), pp_offset, corr[SW-1:0]);
        acc = pp_offset;
        for (int k = 0; k < DW; k++) acc = acc + pp_rows[k];
        if (sel_real) prod = -(s_i + t_i) * re_i + (t_i - s_i) * im_i;
        else          prod = -(s_i + t_i) * im_i + (s_i - t_i) * re_i;
        chk($sformatf("%s sum %s", sel_real ? "R6" : "R7", note), acc, prod[SW-1:0]);
    endtask

    task automatic apply(input logic m, input logic [CW-1:0] s, input logic [CW-1:0] t,
                         input logic [DW-1:0] re, input logic [DW-1:0] im, input string note);
        @(posedge clk);
        #1;
        sel_real = m;
        coef_s   = s;
        coef_t   = t;
        data_re  = re;
        data_im  = im;
        @(negedge clk);
        check_now(note);
    endtask

    initial begin
        logic [CW-1:0] cset [4];
        logic [DW-1:0] dset [4];
        cset = '{CW'(1) << (CW - 1), ~(CW'(1) << (CW - 1)), '0, '1};
        dset = '{DW'(1) << (DW - 1), ~(DW'(1) << (DW - 1)), '0, '1};
        sel_real = 1'b0; coef_s = '0; coef_t = '0; data_re = '0; data_im = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_now("reset state");
        rst = 1'b0;
        // Hand-picked small cases in both modes.
        apply(1'b1, CW'(5),  CW'(-9), DW'(3),  DW'(-2), "small real");
        apply(1'b0, CW'(5),  CW'(-9), DW'(3),  DW'(-2), "small imag");
        apply(1'b1, CW'(-1), CW'(1),  DW'(1),  DW'(1),  "unit real");
        apply(1'b0, CW'(-1), CW'(1),  DW'(1),  DW'(1),  "unit imag");
        // R8: every combination of extreme coefficients and data, both parts.
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++)
                    for (int d = 0; d < 4; d++)
                        for (int m = 0; m < 2; m++)
                            apply(1'(m), cset[a], cset[b], dset[c], dset[d], "R8 extreme");
        // Random patterns.
        for (int n = 0; n < 400; n++)
            apply(1'($urandom), CW'($urandom), CW'($urandom), DW'($urandom), DW'($urandom), "random");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule